// File: doc/BRIEF.md
# Indirect Control Status Register File

This block is the host-facing register window of a network controller. It holds four 16-bit control/status registers behind two access ports. The host first writes a 2-bit register number into an index register. It then reads or writes the chosen register through a data port. The index stays in place until the host writes it again, so a driver can select register 0 once and then poll or acknowledge it as often as it needs.

Register 0 is the command-and-status word. It holds the init, start, stop and transmit-demand commands, which are set by writing a one. It also holds a running/stopped state machine with two states: ST_STOPPED and ST_RUNNING. Transition T_START (ST_STOPPED to ST_RUNNING) is taken on a start write that carries no stop. Transition T_STOP (ST_RUNNING to ST_STOPPED) is taken on any stop write. A stop written while already in ST_STOPPED keeps the machine there.

Seven event flags are set by the transmit, receive and DMA logic and cleared by the host writing a one. An error summary and an interrupt-pending bit are derived from these flags, and an interrupt enable bit gates the interrupt output. Registers 1 to 3 hold the 24-bit init-block address and a 3-bit bus-mode setting. Both are driven out to the rest of the controller. The host can reach registers 1 to 3 only while the controller is stopped.

Top module: `csr_indirect_file`

## Requirements
- R1: The index register is loaded by `idx_we` and keeps its value until the next `idx_we`. A data-port access uses the index held before the clock edge, even if `idx_we` is asserted in the same cycle.
- R2: In ST_RUNNING, registers 1, 2 and 3 read as 0x0000 on `dat_rdata`, and data-port writes to them are dropped.
- R3: In register 0, init (bit 0), start (bit 1), stop (bit 2) and transmit demand (bit 3) are set by writing a one. Writing a zero to any of them changes nothing. Transmit demand stays set until reset.
- R4: Register 0 flags are init done (bit 8), transmit interrupt (bit 9), receive interrupt (bit 10), memory error (bit 11), missed frame (bit 12), SQE error (bit 13) and babble (bit 14). They are set by `evt[0]` to `evt[6]` in that order and cleared by writing a one to their bit in register 0.
- R5: Register 0 bit 15 is read-only and reads as the OR of bits 11, 12, 13 and 14.
- R6: Register 0 bit 7 (interrupt pending) is the OR of bits 8, 9, 10 and 15. Bit 6 (interrupt enable) is read/write. `irq` is high exactly when bits 6 and 7 are both one.
- R7: A stop write clears init, start, transmitter-on (bit 4) and receiver-on (bit 5), sets stop and enters ST_STOPPED. A stop written together with start wins.
- R8: A start write in ST_STOPPED without stop enters ST_RUNNING: start, bit 4 and bit 5 become one and stop becomes zero. Init and transmit demand are kept.
- R9: After reset the block is in ST_STOPPED. Register 0 reads 0x0004, registers 1 to 3 read 0x0000, the index is 0 and `irq` is low.
- R10: Register 1 bit 0 always reads 0. Register 2 bits 15:8 and register 3 bits 15:3 read 0 and ignore writes. `init_addr` equals {register 2 bits 7:0, register 1}, and `bus_cfg` equals register 3 bits 2:0.
- R11: When an event and a host write-one-to-clear hit the same flag in the same cycle, the flag is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| idx_we | input | 1 | Load the index register |
| idx_wdata | input | 2 | New register number |
| dat_we | input | 1 | Write the selected register |
| dat_wdata | input | 16 | Data-port write value |
| dat_rdata | output | 16 | Selected register contents (0 when locked) |
| evt | input | 7 | Flag-setting events, bit k sets register 0 bit 8+k |
| irq | output | 1 | Interrupt request |
| init_addr | output | 24 | Init-block address |
| bus_cfg | output | 3 | Bus-mode settings from register 3 |

## Verification
The case that needs the most care is a hardware event and a host acknowledge landing on the same flag in one cycle. It is the second such case the block has, after a start and a stop command arriving in the same register-0 write. Both are provoked on purpose in directed steps. They are also hit many times by random stimulus that drives sparse event vectors at the same time as random register-0 writes. A bench model applies the stated priorities (the event outranks the clear, stop outranks start), and `dat_rdata` and `irq` are compared against that model on the following cycle. A third overlap is an index change and a data write in the same cycle. That case is judged by checking which register took the write.

// File: rtl/csr_pkg.sv
package csr_pkg;

    localparam int unsigned DATA_W    = 16;
    localparam int unsigned NUM_REGS  = 4;
    localparam int unsigned IDX_W     = $clog2(NUM_REGS);
    localparam int unsigned NUM_FLAGS = 7;
    localparam int unsigned FLAG_LSB  = 8;
    localparam int unsigned FLAG_MSB  = FLAG_LSB + NUM_FLAGS - 1;

    localparam int unsigned B_INIT  = 0;
    localparam int unsigned B_START = 1;
    localparam int unsigned B_STOP  = 2;
    localparam int unsigned B_TDMD  = 3;
    localparam int unsigned B_TXON  = 4;
    localparam int unsigned B_RXON  = 5;
    localparam int unsigned B_IEN   = 6;
    localparam int unsigned B_INTR  = 7;
    localparam int unsigned B_ERR   = 15;

    localparam int unsigned ADDR_LO_W = 16;
    localparam int unsigned ADDR_HI_W = 8;
    localparam int unsigned ADDR_W    = ADDR_LO_W + ADDR_HI_W;
    localparam int unsigned CFG_W     = 3;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_t;

    typedef struct packed {
        logic tdmd;
        logic stop;
        logic start;
        logic init;
    } cmd_t;

endpackage

// File: rtl/csr_run_fsm.sv
module csr_run_fsm
    import csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  cmd_t       cmd_wdata,
    output run_state_t state_q,
    output logic       init_bit,
    output logic       tdmd_bit,
    output logic       start_bit,
    output logic       stop_bit,
    output logic       xmit_on,
    output logic       recv_on
);

    run_state_t state_d;
    logic       go_stop;
    logic       go_start;

    assign go_stop  = cmd_we && cmd_wdata.stop;
    assign go_start = cmd_we && cmd_wdata.start && !cmd_wdata.stop;

    // Next-state logic: T_START and T_STOP
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (go_start) state_d = ST_RUNNING;   // T_START
            ST_RUNNING: if (go_stop)  state_d = ST_STOPPED;   // T_STOP
            default:    state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    // Command latches that are not implied by the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_bit <= 1'b0;
            tdmd_bit <= 1'b0;
        end else begin
            if (go_stop)
                init_bit <= 1'b0;
            else if (cmd_we && cmd_wdata.init)
                init_bit <= 1'b1;
            if (cmd_we && cmd_wdata.tdmd)
                tdmd_bit <= 1'b1;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        start_bit = 1'b0;
        stop_bit  = 1'b0;
        xmit_on   = 1'b0;
        recv_on   = 1'b0;
        unique case (state_q)
            ST_STOPPED: stop_bit = 1'b1;
            ST_RUNNING: begin
                start_bit = 1'b1;
                xmit_on   = 1'b1;
                recv_on   = 1'b1;
            end
            default: stop_bit = 1'b1;
        endcase
    end

endmodule

// File: rtl/csr_flag_bank.sv
module csr_flag_bank #(
    parameter int unsigned NUM_FLAGS = 7,
    parameter logic [NUM_FLAGS-1:0] ERR_MASK = 7'b1111000,
    parameter logic [NUM_FLAGS-1:0] IRQ_MASK = 7'b0000111
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_evt,
    input  logic                 clr_we,
    input  logic [NUM_FLAGS-1:0] clr_mask,
    input  logic                 ien_we,
    input  logic                 ien_wdata,
    output logic [NUM_FLAGS-1:0] flags,
    output logic                 ien,
    output logic                 err_sum,
    output logic                 intr_pend,
    output logic                 irq
);

    // One sticky flop per flag; the event outranks the clear
    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags[k] <= 1'b0;
            else if (set_evt[k])
                flags[k] <= 1'b1;
            else if (clr_we && clr_mask[k])
                flags[k] <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ien <= 1'b0;
        else if (ien_we) ien <= ien_wdata;
    end

    assign err_sum   = |(flags & ERR_MASK);
    assign intr_pend = (|(flags & IRQ_MASK)) | err_sum;
    assign irq       = intr_pend & ien;

endmodule

// File: rtl/csr_cfg_regs.sv
module csr_cfg_regs #(
    parameter int unsigned ADDR_LO_W = 16,
    parameter int unsigned ADDR_HI_W = 8,
    parameter int unsigned CFG_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lo_we,
    input  logic [ADDR_LO_W-1:1] lo_wdata,
    input  logic                 hi_we,
    input  logic [ADDR_HI_W-1:0] hi_wdata,
    input  logic                 cfg_we,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [ADDR_LO_W-1:0] addr_lo,
    output logic [ADDR_HI_W-1:0] addr_hi,
    output logic [CFG_W-1:0]     cfg
);

    logic [ADDR_LO_W-1:1] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q    <= '0;
            addr_hi <= '0;
            cfg     <= '0;
        end else begin
            if (lo_we)  lo_q    <= lo_wdata;
            if (hi_we)  addr_hi <= hi_wdata;
            if (cfg_we) cfg     <= cfg_wdata;
        end
    end

    // Word alignment: bit 0 of the low address is never stored
    assign addr_lo = {lo_q, 1'b0};

endmodule

// File: rtl/csr_indirect_file.sv
module csr_indirect_file
    import csr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                idx_we,
    input  logic [IDX_W-1:0]    idx_wdata,
    input  logic                dat_we,
    input  logic [DATA_W-1:0]   dat_wdata,
    output logic [DATA_W-1:0]   dat_rdata,
    input  logic [NUM_FLAGS-1:0] evt,
    output logic                irq,
    output logic [ADDR_W-1:0]   init_addr,
    output logic [CFG_W-1:0]    bus_cfg
);

    logic [IDX_W-1:0]     idx_q;
    run_state_t           run_state;
    logic                 init_bit, tdmd_bit, start_bit, stop_bit;
    logic                 xmit_on, recv_on;
    logic [NUM_FLAGS-1:0] flags;
    logic                 ien, err_sum, intr_pend;
    logic [ADDR_LO_W-1:0] addr_lo;
    logic [ADDR_HI_W-1:0] addr_hi;
    logic [CFG_W-1:0]     cfg;
    logic                 wr0, cfg_open;
    logic                 wr1, wr2, wr3;
    cmd_t                 cmd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_we) idx_q <= idx_wdata;
    end

    assign cfg_open = (run_state == ST_STOPPED);
    assign wr0 = dat_we && (idx_q == IDX_W'(0));
    assign wr1 = dat_we && cfg_open && (idx_q == IDX_W'(1));
    assign wr2 = dat_we && cfg_open && (idx_q == IDX_W'(2));
    assign wr3 = dat_we && cfg_open && (idx_q == IDX_W'(3));

    assign cmd = '{tdmd:  dat_wdata[B_TDMD],
                   stop:  dat_wdata[B_STOP],
                   start: dat_wdata[B_START],
                   init:  dat_wdata[B_INIT]};

    csr_run_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (wr0),
        .cmd_wdata (cmd),
        .state_q   (run_state),
        .init_bit  (init_bit),
        .tdmd_bit  (tdmd_bit),
        .start_bit (start_bit),
        .stop_bit  (stop_bit),
        .xmit_on   (xmit_on),
        .recv_on   (recv_on)
    );

    csr_flag_bank #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_evt   (evt),
        .clr_we    (wr0),
        .clr_mask  (dat_wdata[FLAG_MSB:FLAG_LSB]),
        .ien_we    (wr0),
        .ien_wdata (dat_wdata[B_IEN]),
        .flags     (flags),
        .ien       (ien),
        .err_sum   (err_sum),
        .intr_pend (intr_pend),
        .irq       (irq)
    );

    csr_cfg_regs #(
        .ADDR_LO_W (ADDR_LO_W),
        .ADDR_HI_W (ADDR_HI_W),
        .CFG_W     (CFG_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .lo_we     (wr1),
        .lo_wdata  (dat_wdata[ADDR_LO_W-1:1]),
        .hi_we     (wr2),
        .hi_wdata  (dat_wdata[ADDR_HI_W-1:0]),
        .cfg_we    (wr3),
        .cfg_wdata (dat_wdata[CFG_W-1:0]),
        .addr_lo   (addr_lo),
        .addr_hi   (addr_hi),
        .cfg       (cfg)
    );

    assign init_addr = {addr_hi, addr_lo};
    assign bus_cfg   = cfg;

    // Read multiplexer with lockout of registers 1..3 while running
    always_comb begin
        dat_rdata = '0;
        unique case (idx_q)
            IDX_W'(0): begin
                dat_rdata[B_INIT]  = init_bit;
                dat_rdata[B_START] = start_bit;
                dat_rdata[B_STOP]  = stop_bit;
                dat_rdata[B_TDMD]  = tdmd_bit;
                dat_rdata[B_TXON]  = xmit_on;
                dat_rdata[B_RXON]  = recv_on;
                dat_rdata[B_IEN]   = ien;
                dat_rdata[B_INTR]  = intr_pend;
                dat_rdata[FLAG_MSB:FLAG_LSB] = flags;
                dat_rdata[B_ERR]   = err_sum;
            end
            IDX_W'(1): if (cfg_open) dat_rdata = addr_lo;
            IDX_W'(2): if (cfg_open) dat_rdata[ADDR_HI_W-1:0] = addr_hi;
            IDX_W'(3): if (cfg_open) dat_rdata[CFG_W-1:0] = cfg;
            default:   dat_rdata = '0;
        endcase
    end

endmodule

// File: rtl/csr_file_checker.sv
module csr_file_checker
    import csr_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [IDX_W-1:0]     idx_q,
    input logic                 dat_we,
    input logic [DATA_W-1:0]    dat_wdata,
    input logic [NUM_FLAGS-1:0] evt,
    input logic [NUM_FLAGS-1:0] flags,
    input logic                 ien,
    input logic                 irq,
    input run_state_t           run_state,
    input logic [ADDR_W-1:0]    init_addr,
    input logic [CFG_W-1:0]     bus_cfg
);

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == ST_RUNNING && dat_we && idx_q != '0)
        |=> ($stable(init_addr) && $stable(bus_cfg))); // R2

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && idx_q == '0 && evt == '0)
        |=> ((flags & $past(dat_wdata[FLAG_MSB:FLAG_LSB])) == '0)); // R4

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((flags & $past(evt)) == $past(evt))); // R11

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ien); // R6

    AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && idx_q == '0 && dat_wdata[B_STOP])
        |=> (run_state == ST_STOPPED)); // R7

    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == ST_RUNNING && $past(run_state) == ST_STOPPED)
        |-> $past(dat_we && idx_q == '0 && dat_wdata[B_START])); // R8

endmodule

bind csr_indirect_file csr_file_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_q     (idx_q),
    .dat_we    (dat_we),
    .dat_wdata (dat_wdata),
    .evt       (evt),
    .flags     (flags),
    .ien       (ien),
    .irq       (irq),
    .run_state (run_state),
    .init_addr (init_addr),
    .bus_cfg   (bus_cfg)
);

// File: tb/tb_csr_indirect_file.sv
`timescale 1ns/1ps
module tb_csr_indirect_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        idx_we = 1'b0;
    logic [1:0]  idx_wdata = '0;
    logic        dat_we = 1'b0;
    logic [15:0] dat_wdata = '0;
    logic [15:0] dat_rdata;
    logic [6:0]  evt = '0;
    logic        irq;
    logic [23:0] init_addr;
    logic [2:0]  bus_cfg;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    csr_indirect_file dut (
        .clk(clk), .rst_n(rst_n),
        .idx_we(idx_we), .idx_wdata(idx_wdata),
        .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .evt(evt), .irq(irq), .init_addr(init_addr), .bus_cfg(bus_cfg)
    );

    // Reference model state, built from the requirements
    logic        m_run, m_init, m_tdmd, m_ien;
    logic [6:0]  m_flags;
    logic [15:0] m_r1;
    logic [7:0]  m_r2;
    logic [2:0]  m_r3;
    logic [1:0]  m_idx;

    function automatic logic m_err();
        return |m_flags[6:3];
    endfunction

    function automatic logic m_intr();
        return (|m_flags[2:0]) | m_err();
    endfunction

    function automatic logic [15:0] exp_reg0();
        return {m_err(), m_flags, m_intr(), m_ien, m_run, m_run,
                m_tdmd, !m_run, m_run, m_init};
    endfunction

    function automatic logic [15:0] exp_rd();
        if (m_idx == 2'd0) return exp_reg0();
        if (m_run) return 16'h0000;
        case (m_idx)
            2'd1:    return m_r1;
            2'd2:    return {8'h00, m_r2};
            default: return {13'h0, m_r3};
        endcase
    endfunction

    task automatic model_reset();
        m_run = 0; m_init = 0; m_tdmd = 0; m_ien = 0;
        m_flags = '0; m_r1 = '0; m_r2 = '0; m_r3 = '0; m_idx = '0;
    endtask

    task automatic model_step(input logic iwe, input logic [1:0] iv,
                              input logic dwe, input logic [15:0] dv,
                              input logic [6:0] ev);
        logic [1:0] old_idx = m_idx;
        logic       old_run = m_run;
        if (iwe) m_idx = iv;
        if (dwe && old_idx == 2'd0) begin
            m_flags = (m_flags & ~dv[14:8]) | ev;
            m_ien = dv[6];
            if (dv[2]) begin
                m_run = 0; m_init = 0;
            end else begin
                if (dv[0]) m_init = 1;
                if (dv[1] && !old_run) m_run = 1;
            end
            if (dv[3]) m_tdmd = 1;
        end else begin
            m_flags = m_flags | ev;
        end
        if (dwe && old_idx != 2'd0 && !old_run) begin
            case (old_idx)
                2'd1:    m_r1 = dv & 16'hFFFE;
                2'd2:    m_r2 = dv[7:0];
                default: m_r3 = dv[2:0];
            endcase
        end
    endtask

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "dat_rdata", 32'(dat_rdata), 32'(exp_rd()));
        chk(tag, "irq", 32'(irq), 32'(m_intr() & m_ien));
        chk(tag, "init_addr", 32'(init_addr), 32'({m_r2, m_r1}));
        chk(tag, "bus_cfg", 32'(bus_cfg), 32'(m_r3));
    endtask

    // Drive at the falling edge, sample at the next falling edge
    task automatic step(input logic iwe, input logic [1:0] iv,
                        input logic dwe, input logic [15:0] dv,
                        input logic [6:0] ev, input string tag);
        idx_we = iwe; idx_wdata = iv; dat_we = dwe; dat_wdata = dv; evt = ev;
        @(posedge clk);
        model_step(iwe, iv, dwe, dv, ev);
        @(negedge clk);
        idx_we = 0; dat_we = 0; evt = '0;
        check_all(tag);
    endtask

    task automatic sel(input logic [1:0] v, input string tag);
        step(1, v, 0, 16'h0, 7'h0, tag);
    endtask

    task automatic wr(input logic [15:0] v, input string tag);
        step(0, 2'd0, 1, v, 7'h0, tag);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk("R9", "reg0 literal", 32'(dat_rdata), 32'h0004);
        check_all("R9");
        sel(2'd1, "R9");
        sel(2'd3, "R9");

        // R10: reserved and forced bits, address and config outputs
        sel(2'd1, "R10"); wr(16'hFFFF, "R10");
        chk("R10", "reg1 literal", 32'(dat_rdata), 32'h0000FFFE);
        sel(2'd2, "R10"); wr(16'hABCD, "R10");
        chk("R10", "reg2 literal", 32'(dat_rdata), 32'h000000CD);
        sel(2'd3, "R10"); wr(16'hFFFF, "R10");
        chk("R10", "init_addr literal", 32'(init_addr), 32'h00CDFFFE);

        // R1: index persists; data write uses old index when both change
        wr(16'h0002, "R1");
        step(1, 2'd0, 1, 16'h0005, 7'h0, "R1");
        chk("R1", "bus_cfg literal", 32'(bus_cfg), 32'h5);
        chk("R1", "reg0 untouched", 32'(dat_rdata), 32'h0004);

        // R3: zero writes do nothing; ones set init and transmit demand
        wr(16'h0000, "R3");
        wr(16'h0009, "R3");
        chk("R3", "reg0 literal", 32'(dat_rdata), 32'h000D);

        // R8: start while stopped
        wr(16'h0002, "R8");
        chk("R8", "reg0 literal", 32'(dat_rdata), 32'h003B);

        // R2: locked registers while running
        sel(2'd1, "R2");
        chk("R2", "locked read", 32'(dat_rdata), 32'h0);
        wr(16'h1234, "R2");
        sel(2'd3, "R2"); wr(16'h0002, "R2");

        // R7: stop and start together, stop wins
        sel(2'd0, "R7");
        wr(16'h0006, "R7");
        chk("R7", "reg0 literal", 32'(dat_rdata), 32'h000C);
        sel(2'd1, "R7");
        chk("R7", "reg1 kept", 32'(dat_rdata), 32'h0000FFFE);
        sel(2'd0, "R7");

        // R4: events set, write-one clears
        step(0, 2'd0, 0, 16'h0, 7'h7F, "R4");
        chk("R4", "reg0 literal", 32'(dat_rdata), 32'hFF8C);
        wr(16'h0100, "R4");
        // R5: summary holds while one error flag remains
        wr(16'h3E00, "R5");
        chk("R5", "summary", 32'(dat_rdata[15]), 32'h1);
        wr(16'h4000, "R5");
        // R6: enable, pending, output
        wr(16'h0040, "R6");
        step(0, 2'd0, 0, 16'h0, 7'h04, "R6");
        chk("R6", "irq literal", 32'(irq), 32'h1);
        wr(16'h0000, "R6");
        chk("R6", "irq masked", 32'(irq), 32'h0);
        // R11: event and clear on the same flag
        step(0, 2'd0, 1, 16'h0240, 7'h02, "R11");
        chk("R11", "tint kept", 32'(dat_rdata[9]), 32'h1);
        wr(16'h7F40, "R11");

        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic        iwe = ($urandom % 4) == 0;
            logic [1:0]  iv  = 2'($urandom);
            logic        dwe = ($urandom % 2) == 0;
            logic [15:0] dv  = 16'($urandom);
            logic [6:0]  ev  = 7'($urandom & $urandom & $urandom);
            string       tg;
            if (($urandom % 4) != 0) dv[2] = 1'b0;
            if (m_idx == 2'd0)  tg = "R4";
            else if (m_run)     tg = "R2";
            else                tg = "R10";
            step(iwe, iv, dwe, dv, ev, tg);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule